// File: doc/BRIEF.md
# Split-Bus Register Datapath with Switchable Bus Link

This block is the execution core of a small processor datapath built around two separate buses. Every general register can put its value on a source bus, and every general register loads from a destination bus. A switchable link copies the source bus onto the destination bus when it is closed. When it is open, the destination bus is driven by the arithmetic unit's result or by an external data input. The arithmetic unit is purely combinational. It takes its first operand from the source bus and its second operand from an operand latch that loads from the destination bus. Because its result can be written straight back through the destination bus, no result register is needed.

Each clock cycle executes one control step. A control step is given as a set of enables: one output enable and one load enable per register, a load enable for the operand latch, the link enable, a result enable, an external-data enable and an ALU operation code. A register-to-register add takes two steps. In the first, one operand crosses the link into the operand latch. In the second, the other operand goes onto the source bus and the result is written to the destination. The registers are edge-triggered, so one register can be both read and written in the same step. A step that would place two drivers on either bus is refused. It is flagged and changes no state.

Top module: `dual_bus_datapath`

## Requirements
- R1: After synchronous reset every register, the operand latch, the carry flag, the error flag and both captured bus outputs are zero.
- R2: The source bus carries the value of the one register whose output enable is set, or zero when none is set. It appears on `bus_a_q` one cycle after the step.
- R3: With `link_en` set, the destination bus equals the source bus, and every register or operand latch with its load enable set takes that value at the clock edge.
- R4: With `res_en` set, the ALU result drives the destination bus and is written to the loading register in the same step.
- R5: A two-step sequence (link Ri into the latch, then put Rj on the source bus with the result going to Rk) leaves Rk equal to Rj op Ri for any i, j and k.
- R6: A register may be the source and the destination of the same step. It reads its old value and stores the new one, in either operand order.
- R7: ALU codes are: 0 add (A+Y), 1 subtract (A−Y modulo 2^W), 2 AND, 3 OR, 4 XOR, 5 pass A. Codes 6 and 7 give zero. A is the source bus and Y is the operand latch.
- R8: On a legal step with `res_en` set, code 0 sets carry to the carry-out of A+Y and code 1 sets carry to 1 exactly when A ≥ Y. All other steps leave carry unchanged.
- R9: A step with more than one register output enable set raises `err_q` on the next cycle and changes no register, latch or carry.
- R10: A step with more than one of `link_en`, `res_en` and `ext_en` set raises `err_q` on the next cycle and changes no register, latch or carry.
- R11: A step with no load enable set leaves every register unchanged.
- R12: With `ext_en` set, `ext_data` drives the destination bus and is captured by the loading registers.
- R13: Several registers with their load enables set in one step all take the same destination-bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_oe | input | NREG | Per-register output enable onto the source bus |
| dst_le | input | NREG | Per-register load enable from the destination bus |
| y_le | input | 1 | Operand latch load enable |
| link_en | input | 1 | Closes the link from the source bus to the destination bus |
| res_en | input | 1 | Drives the ALU result onto the destination bus |
| ext_en | input | 1 | Drives ext_data onto the destination bus |
| ext_data | input | W | External data value |
| alu_op | input | 3 | ALU operation code |
| bus_a_q | output | W | Source bus value captured at the last step |
| bus_b_q | output | W | Destination bus value captured at the last step |
| carry_q | output | 1 | Carry flag |
| err_q | output | 1 | Set for one cycle after a refused step |

## Verification
A corrupted register or operand latch stays hidden until a later step reads it. It then shows on `bus_a_q` one cycle after a read-out step, or one step later as a wrong result on `bus_b_q`. A wrong legality decision shows in the very next cycle, either on `err_q` or as register contents that changed when they should have held. For that reason the bench reads registers back right after each operation, so every fault appears within two or three cycles of its cause.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_PASS = 3'd5
  } alu_op_e;

  localparam int OP_BITS = 3;
endpackage

// File: rtl/dbd_alu.sv
module dbd_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0]            a_in,
  input  logic [W-1:0]            y_in,
  input  logic [dbd_pkg::OP_BITS-1:0] op,
  output logic [W-1:0]            result,
  output logic                    cout,
  output logic                    carry_upd
);
  import dbd_pkg::*;

  logic [W:0] sum_ext;
  logic [W:0] dif_ext;

  always_comb begin
    sum_ext = {1'b0, a_in} + {1'b0, y_in};
    dif_ext = {1'b0, a_in} + {1'b0, ~y_in} + {{W{1'b0}}, 1'b1};
  end

  always_comb begin
    result    = '0;
    cout      = 1'b0;
    carry_upd = 1'b0;
    case (op)
      OP_ADD:  begin result = sum_ext[W-1:0]; cout = sum_ext[W]; carry_upd = 1'b1; end
      OP_SUB:  begin result = dif_ext[W-1:0]; cout = dif_ext[W]; carry_upd = 1'b1; end
      OP_AND:  result = a_in & y_in;
      OP_OR:   result = a_in | y_in;
      OP_XOR:  result = a_in ^ y_in;
      OP_PASS: result = a_in;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/dbd_regfile.sv
module dbd_regfile #(
  parameter int NREG = 8,
  parameter int W    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] src_oe,
  input  logic [NREG-1:0] dst_le,
  input  logic            wr_ok,
  input  logic [W-1:0]    bus_b,
  output logic [W-1:0]    bus_a
);
  logic [W-1:0] regs [NREG];

  always_comb begin
    bus_a = '0;
    for (int i = 0; i < NREG; i++) begin
      if (src_oe[i]) bus_a = bus_a | regs[i];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                    regs[g] <= '0;
      else if (wr_ok && dst_le[g]) regs[g] <= bus_b;
    end

    // R3
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ok && dst_le[g]) |=> (regs[g] == $past(bus_b)));

    // R11
    no_load_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_ok && dst_le[g]) |=> $stable(regs[g]));
  end
endmodule

// File: rtl/dbd_step_guard.sv
module dbd_step_guard #(
  parameter int NREG = 8,
  parameter int W    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] src_oe,
  input  logic            link_en,
  input  logic            res_en,
  input  logic            ext_en,
  input  logic [W-1:0]    bus_a,
  input  logic [W-1:0]    alu_res,
  input  logic [W-1:0]    ext_data,
  output logic [W-1:0]    bus_b,
  output logic            step_ok
);
  localparam int CW = $clog2(NREG + 1);

  logic [CW-1:0] src_cnt;
  logic [1:0]    drv_cnt;

  always_comb begin
    src_cnt = '0;
    for (int i = 0; i < NREG; i++) src_cnt = src_cnt + CW'(src_oe[i]);
    drv_cnt = 2'(link_en) + 2'(res_en) + 2'(ext_en);
    step_ok = (src_cnt <= CW'(1)) && (drv_cnt <= 2'd1);
  end

  always_comb begin
    bus_b = '0;
    if (step_ok) begin
      if (link_en)     bus_b = bus_a;
      else if (res_en) bus_b = alu_res;
      else if (ext_en) bus_b = ext_data;
    end
  end

  // R3
  link_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ok && link_en) |-> (bus_b == bus_a));

  // R4
  result_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ok && res_en) |-> (bus_b == alu_res));

  // R12
  ext_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ok && ext_en) |-> (bus_b == ext_data));
endmodule

// File: rtl/dual_bus_datapath.sv
module dual_bus_datapath #(
  parameter int NREG = 8,
  parameter int W    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] src_oe,
  input  logic [NREG-1:0] dst_le,
  input  logic            y_le,
  input  logic            link_en,
  input  logic            res_en,
  input  logic            ext_en,
  input  logic [W-1:0]    ext_data,
  input  logic [2:0]      alu_op,
  output logic [W-1:0]    bus_a_q,
  output logic [W-1:0]    bus_b_q,
  output logic            carry_q,
  output logic            err_q
);
  logic [W-1:0] bus_a;
  logic [W-1:0] bus_b;
  logic [W-1:0] alu_res;
  logic [W-1:0] y_q;
  logic         alu_cout;
  logic         alu_cupd;
  logic         step_ok;

  dbd_regfile #(.NREG(NREG), .W(W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .src_oe (src_oe),
    .dst_le (dst_le),
    .wr_ok  (step_ok),
    .bus_b  (bus_b),
    .bus_a  (bus_a)
  );

  dbd_alu #(.W(W)) u_alu (
    .a_in      (bus_a),
    .y_in      (y_q),
    .op        (alu_op),
    .result    (alu_res),
    .cout      (alu_cout),
    .carry_upd (alu_cupd)
  );

  dbd_step_guard #(.NREG(NREG), .W(W)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .src_oe   (src_oe),
    .link_en  (link_en),
    .res_en   (res_en),
    .ext_en   (ext_en),
    .bus_a    (bus_a),
    .alu_res  (alu_res),
    .ext_data (ext_data),
    .bus_b    (bus_b),
    .step_ok  (step_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q     <= '0;
      carry_q <= 1'b0;
      err_q   <= 1'b0;
      bus_a_q <= '0;
      bus_b_q <= '0;
    end else begin
      if (step_ok && y_le)                 y_q     <= bus_b;
      if (step_ok && res_en && alu_cupd)   carry_q <= alu_cout;
      err_q   <= !step_ok;
      bus_a_q <= bus_a;
      bus_b_q <= bus_b;
    end
  end

  // R9
  refused_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_ok |=> ($stable(y_q) && $stable(carry_q) && err_q));

  // R8
  carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !(step_ok && res_en && alu_cupd) |=> $stable(carry_q));

  // R2
  one_source_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(src_oe) == 1) |=> (bus_a_q == $past(bus_a)));
endmodule

// File: tb/sim_dual_bus_datapath.sv
module sim_dual_bus_datapath;
  localparam int NREG = 8;
  localparam int W    = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NREG-1:0] src_oe = '0;
  logic [NREG-1:0] dst_le = '0;
  logic            y_le = 1'b0, link_en = 1'b0, res_en = 1'b0, ext_en = 1'b0;
  logic [W-1:0]    ext_data = '0;
  logic [2:0]      alu_op = '0;
  logic [W-1:0]    bus_a_q, bus_b_q;
  logic            carry_q, err_q;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] m_r [NREG];
  logic [W-1:0] m_y = '0;
  logic         m_c = 1'b0;

  always #5 clk = ~clk;

  dual_bus_datapath #(.NREG(NREG), .W(W)) u0 (
    .clk(clk), .rst(rst), .src_oe(src_oe), .dst_le(dst_le), .y_le(y_le),
    .link_en(link_en), .res_en(res_en), .ext_en(ext_en), .ext_data(ext_data),
    .alu_op(alu_op), .bus_a_q(bus_a_q), .bus_b_q(bus_b_q),
    .carry_q(carry_q), .err_q(err_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W:0] model_alu(input logic [2:0] op, input logic [W-1:0] a,
                                          input logic [W-1:0] y, input logic cin);
    int s;
    case (op)
      3'd0: begin s = int'(a) + int'(y); return {(s > 65535), 16'(s)}; end
      3'd1: begin s = int'(a) - int'(y); return {(int'(a) >= int'(y)), 16'(s)}; end
      3'd2: return {cin, a & y};
      3'd3: return {cin, a | y};
      3'd4: return {cin, a ^ y};
      3'd5: return {cin, a};
      default: return {cin, 16'h0000};
    endcase
  endfunction

  task automatic step(input logic [NREG-1:0] oe, input logic [NREG-1:0] le, input logic yl,
                      input logic lk, input logic rs, input logic ex,
                      input logic [W-1:0] d, input logic [2:0] op, input string req);
    logic bad;
    logic [W-1:0] a, b;
    logic [W:0] r;
    src_oe = oe; dst_le = le; y_le = yl; link_en = lk; res_en = rs;
    ext_en = ex; ext_data = d; alu_op = op;
    bad = ($countones(oe) > 1) || ((int'(lk) + int'(rs) + int'(ex)) > 1);
    a = '0;
    for (int i = 0; i < NREG; i++) if (oe[i]) a = m_r[i];
    r = model_alu(op, a, m_y, m_c);
    b = lk ? a : (rs ? r[W-1:0] : (ex ? d : '0));
    @(negedge clk);
    chk(err_q == bad, {req, " err"}, int'(err_q), int'(bad));
    if (!bad) begin
      chk(bus_b_q == b, {req, " busB"}, int'(bus_b_q), int'(b));
      for (int i = 0; i < NREG; i++) if (le[i]) m_r[i] = b;
      if (yl) m_y = b;
      if (rs && (op == 3'd0 || op == 3'd1)) m_c = r[W];
    end
    chk(carry_q == m_c, {req, " carry"}, int'(carry_q), int'(m_c));
  endtask

  task automatic read_reg(input int k, input string req);
    step(NREG'(1) << k, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 3'd5, "R2 readout");
    chk(bus_a_q == m_r[k], req, int'(bus_a_q), int'(m_r[k]));
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < NREG; k++) read_reg(k, req);
  endtask

  task automatic load_all(input int seed);
    for (int k = 0; k < NREG; k++)
      step('0, NREG'(1) << k, 1'b0, 1'b0, 1'b0, 1'b1,
           W'(k * 16'h2345 + seed * 16'h0F1B + 16'h0F0F), 3'd0, "R12 load");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) m_r[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(bus_a_q == 0 && bus_b_q == 0, "R1 buses", int'(bus_a_q), 0);
    chk(carry_q == 0 && err_q == 0, "R1 flags", int'({carry_q, err_q}), 0);
    read_all("R1 regs zero");
    // R12 external load
    load_all(0);
    read_all("R12 ext load");
    // R13 broadcast
    step('0, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hBEEF, 3'd0, "R13 broadcast");
    read_reg(6, "R13 r6"); read_reg(7, "R13 r7");
    // R3 link copy into register
    step(8'h02, 8'h20, 1'b0, 1'b1, 1'b0, 1'b0, '0, 3'd0, "R3 link");
    read_reg(5, "R3 link copy");
    // R5 / R7 / R4 sweep: Rk = Rj op Ri
    for (int op = 0; op < 8; op++) begin
      load_all(op + 1);
      for (int i = 0; i < NREG; i++) begin
        for (int j = 0; j < NREG; j++) begin
          int k = (i + j + op) % NREG;
          step(NREG'(1) << i, '0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 3'(op), "R5 step1");
          step(NREG'(1) << j, NREG'(1) << k, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'(op), "R7 R4 step2");
          read_reg(k, "R5 R7 result");
        end
      end
    end
    // R6 same register source and destination, both orders
    load_all(11);
    step(8'h08, '0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 3'd0, "R6 a1");
    step(8'h10, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'd0, "R6 a2");
    read_reg(4, "R6 r4 = r3 + r4");
    step(8'h10, '0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 3'd0, "R6 b1");
    step(8'h08, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'd1, "R6 b2");
    read_reg(4, "R6 r4 = r3 - r4");
    // R8 carry boundaries
    step('0, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, 3'd0, "R8 setup");
    step('0, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0001, 3'd0, "R8 setup");
    step(8'h02, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'd0, "R8 add wrap");
    chk(carry_q == 1'b1, "R8 add carry", int'(carry_q), 1);
    step(8'h01, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'd1, "R8 sub equal");
    chk(carry_q == 1'b1, "R8 sub equal carry", int'(carry_q), 1);
    step(8'h02, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'd1, "R8 sub borrow");
    chk(carry_q == 1'b0, "R8 sub borrow", int'(carry_q), 0);
    step(8'h01, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'd4, "R8 xor keeps");
    // R9 two source enables refused
    load_all(5);
    step(8'h03, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, '0, 3'd0, "R9 multi source");
    read_all("R9 regs held");
    // R10 bus-B driver conflicts
    step(8'h01, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, '0, 3'd0, "R10 link+res");
    step(8'h01, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 16'h1234, 3'd0, "R10 link+ext");
    step(8'h01, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 16'h1234, 3'd1, "R10 res+ext");
    read_all("R10 regs held");
    // R9 latch held: pass-through add of latch after refused steps
    step(8'h01, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'd0, "R9 latch via add");
    read_reg(7, "R9 latch held");
    // R11 no load enable
    step(8'h04, '0, 1'b0, 1'b0, 1'b1, 1'b0, '0, 3'd3, "R11 no load");
    step('0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hAAAA, 3'd0, "R11 ext no load");
    read_all("R11 regs held");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule